// File: doc/BRIEF.md
# Remappable Bus Address Decoder

This block sits on a 32-bit processor bus and turns each access address into one select line for the target that answers it. There are three fixed targets: a 4 kB on-chip SRAM, a 32 kB on-chip flash and a 4 kB register page. A fourth window, the lowest 32 kB of the address space, holds the exception vectors. Either flash or SRAM answers there. The block also returns the byte offset inside the selected target and the byte-lane enables for the access. Any access it cannot route raises an abort.

A one-bit map-control register sits at the base of the register page and chooses the low-window target. Reset clears the bit, so flash answers at address zero after reset. Software sets the bit to run the vectors from SRAM and clears it to go back to flash. The rest of the register page is passed through as a select plus an offset, for the peripheral logic to use. The decode path is purely combinational. The only state in the block is the map-control bit.

Top module: `memmap_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the map-control bit clears. After that edge `remap_sram` is 0, `ctl_rdata` is 0, and low-window accesses select flash.
- R2: Addresses 0x0004_0000 to 0x0004_0FFF assert `sel_sram` only, with `local_off` equal to the address minus 0x0004_0000.
- R3: Addresses 0x0008_0000 to 0x0008_7FFF assert `sel_flash` only, with `local_off` equal to the address minus 0x0008_0000.
- R4: Addresses 0xFFFF_0000 to 0xFFFF_0FFF assert `sel_regs` only, with `local_off` equal to the address minus 0xFFFF_0000.
- R5: When the map-control bit is 0, addresses 0x0000_0000 to 0x0000_7FFF select flash, with `local_off` equal to the address.
- R6: A valid write to address 0xFFFF_0000 that does not abort loads bit 0 of `bus_wdata` into the map-control bit at the next clock edge. While the bit is 1, low-window addresses select SRAM with `local_off` equal to address bits 11:0, so offsets of 4 kB and above wrap.
- R7: `ctl_rdata` always shows the map-control bit in bit 0, with bits 31:1 at zero.
- R8: A valid access to any address outside the four windows asserts `bus_abort`. In that case no select is asserted, `local_off` is 0 and `bus_be` is 0.
- R9: The `bus_size` encoding is 0 = byte, 1 = halfword, 2 = word, 3 = reserved (3 aborts). Lanes are little endian: a byte sets lane `addr[1:0]`, a halfword sets lanes 1:0 or 3:2 according to `addr[1]`, and a word sets all four lanes.
- R10: A halfword with `addr[0]`=1, or a word with `addr[1:0]`≠0, aborts, with no select and `bus_be` = 0.
- R11: With `bus_valid` low, all selects, `bus_abort` and `bus_be` are 0, and no write changes the map-control bit.
- R12: Reads of the control address, and writes to any other register-page offset, leave the map-control bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data |
| sel_sram | output | 1 | SRAM selected |
| sel_flash | output | 1 | Flash selected |
| sel_regs | output | 1 | Register page selected |
| bus_abort | output | 1 | Data-abort response |
| local_off | output | 15 | Byte offset inside the selected target |
| bus_be | output | 4 | Little-endian byte-lane enables |
| ctl_rdata | output | 32 | Read value of the map-control register |
| remap_sram | output | 1 | Current map-control bit (1 = SRAM in low window) |

## Verification
Selects, offset, lane enables and abort depend only on the current inputs and the map-control bit. The bench samples them one time step after it drives each access, within the same clock cycle. A control write reaches `remap_sram` and `ctl_rdata` only at the next rising edge. The bench therefore checks the bit just after that edge, and only then sends the low-window access that depends on the new mapping. A reset is checked in the same way, just after the edge on which it is sampled.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    localparam logic [ADDR_W-1:0] LOW_BASE   = 32'h0000_0000;
    localparam logic [ADDR_W-1:0] SRAM_BASE  = 32'h0004_0000;
    localparam logic [ADDR_W-1:0] FLASH_BASE = 32'h0008_0000;
    localparam logic [ADDR_W-1:0] REGS_BASE  = 32'hFFFF_0000;

    localparam int LOW_BYTES   = 32768;
    localparam int SRAM_BYTES  = 4096;
    localparam int FLASH_BYTES = 32768;
    localparam int REGS_BYTES  = 4096;

    localparam int OFF_W     = $clog2(FLASH_BYTES);
    localparam int SRAM_AW   = $clog2(SRAM_BYTES);
    localparam int NUM_WIN   = 4;
    localparam int CTL_OFF   = 0;

    // window indices
    localparam int W_LOW   = 0;
    localparam int W_SRAM  = 1;
    localparam int W_FLASH = 2;
    localparam int W_REGS  = 3;

    localparam logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE =
        {REGS_BASE, FLASH_BASE, SRAM_BASE, LOW_BASE};
    localparam logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BYTES =
        {32'(REGS_BYTES), 32'(FLASH_BYTES), 32'(SRAM_BYTES), 32'(LOW_BYTES)};

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_SRAM  = 2'd1,
        TGT_FLASH = 2'd2,
        TGT_REGS  = 2'd3
    } target_e;

    typedef struct packed {
        target_e          tgt;
        logic [OFF_W-1:0] off;
    } route_t;

    function automatic logic [LANES-1:0] lane_mask(input acc_size_e sz,
                                                   input logic [1:0] lo);
        logic [LANES-1:0] m;
        case (sz)
            SZ_BYTE: m = LANES'(1) << lo;
            SZ_HALF: m = LANES'(3) << {lo[1], 1'b0};
            SZ_WORD: m = '1;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic misaligned(input acc_size_e sz, input logic [1:0] lo);
        case (sz)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return lo[0];
            SZ_WORD: return |lo;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/mm_window_match.sv
module mm_window_match
    import memmap_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE  = '0,
    parameter logic [ADDR_W-1:0] BYTES = 32'd4096
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [OFF_W-1:0]  off
);
    logic [ADDR_W-1:0] delta;

    always_comb begin
        delta = addr - BASE;
        hit   = (delta < BYTES);
        off   = delta[OFF_W-1:0];
    end
endmodule

// File: rtl/mm_lane_gen.sv
module mm_lane_gen
    import memmap_pkg::*;
(
    input  acc_size_e        size,
    input  logic [1:0]       addr_lo,
    output logic [LANES-1:0] lanes,
    output logic             bad_align
);
    always_comb begin
        lanes     = lane_mask(size, addr_lo);
        bad_align = misaligned(size, addr_lo);
    end
endmodule

// File: rtl/mm_remap_reg.sv
module mm_remap_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_bit,
    output logic remap
);
    always_ff @(posedge clk) begin
        if (rst)
            remap <= 1'b0;
        else if (wr_en)
            remap <= wr_bit;
    end
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
    import memmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              sel_sram,
    output logic              sel_flash,
    output logic              sel_regs,
    output logic              bus_abort,
    output logic [OFF_W-1:0]  local_off,
    output logic [LANES-1:0]  bus_be,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic              remap_sram
);
    logic [NUM_WIN-1:0]            win_hit;
    logic [NUM_WIN-1:0][OFF_W-1:0] win_off;
    logic [LANES-1:0]              raw_lanes;
    logic                          bad_align;
    route_t                        route;
    logic                          ctl_wr;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        mm_window_match #(
            .BASE (WIN_BASE[i]),
            .BYTES(WIN_BYTES[i])
        ) u_match (
            .addr(bus_addr),
            .hit (win_hit[i]),
            .off (win_off[i])
        );
    end

    mm_lane_gen u_lanes (
        .size     (acc_size_e'(bus_size)),
        .addr_lo  (bus_addr[1:0]),
        .lanes    (raw_lanes),
        .bad_align(bad_align)
    );

    // window priority is irrelevant: the windows do not overlap
    always_comb begin
        route.tgt = TGT_NONE;
        route.off = '0;
        if (win_hit[W_LOW]) begin
            if (remap_sram) begin
                route.tgt = TGT_SRAM;
                route.off = OFF_W'(win_off[W_LOW][SRAM_AW-1:0]);
            end else begin
                route.tgt = TGT_FLASH;
                route.off = win_off[W_LOW];
            end
        end else if (win_hit[W_SRAM]) begin
            route.tgt = TGT_SRAM;
            route.off = win_off[W_SRAM];
        end else if (win_hit[W_FLASH]) begin
            route.tgt = TGT_FLASH;
            route.off = win_off[W_FLASH];
        end else if (win_hit[W_REGS]) begin
            route.tgt = TGT_REGS;
            route.off = win_off[W_REGS];
        end
    end

    always_comb begin
        bus_abort = bus_valid && (bad_align || route.tgt == TGT_NONE);
        if (bus_valid && !bus_abort) begin
            sel_sram  = (route.tgt == TGT_SRAM);
            sel_flash = (route.tgt == TGT_FLASH);
            sel_regs  = (route.tgt == TGT_REGS);
            local_off = route.off;
            bus_be    = raw_lanes;
        end else begin
            sel_sram  = 1'b0;
            sel_flash = 1'b0;
            sel_regs  = 1'b0;
            local_off = '0;
            bus_be    = '0;
        end
        ctl_wr = sel_regs && bus_write && (local_off == OFF_W'(CTL_OFF));
    end

    mm_remap_reg u_remap (
        .clk   (clk),
        .rst   (rst),
        .wr_en (ctl_wr),
        .wr_bit(bus_wdata[0]),
        .remap (remap_sram)
    );

    assign ctl_rdata = {{(DATA_W-1){1'b0}}, remap_sram};

endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk
    import memmap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              sel_sram,
    input logic              sel_flash,
    input logic              sel_regs,
    input logic              bus_abort,
    input logic [OFF_W-1:0]  local_off,
    input logic [LANES-1:0]  bus_be,
    input logic [DATA_W-1:0] ctl_rdata,
    input logic              remap_sram
);
    logic in_map;
    logic ctl_write;
    assign in_map = (bus_addr <= 32'h0000_7FFF)
                 || (bus_addr >= 32'h0004_0000 && bus_addr <= 32'h0004_0FFF)
                 || (bus_addr >= 32'h0008_0000 && bus_addr <= 32'h0008_7FFF)
                 || (bus_addr >= 32'hFFFF_0000 && bus_addr <= 32'hFFFF_0FFF);
    assign ctl_write = bus_valid && bus_write && bus_addr == 32'hFFFF_0000 && bus_size != 2'd3;

    AST_RESET_FLASH: assert property (@(posedge clk) rst |=> !remap_sram && ctl_rdata == '0); // R1

    AST_SRAM_OFFSET: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_abort && bus_addr[31:12] == 20'h00040
        |-> sel_sram && local_off == OFF_W'(bus_addr[11:0])); // R2

    AST_LOW_TARGET: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_abort && bus_addr <= 32'h0000_7FFF
        |-> (remap_sram ? sel_sram : sel_flash)); // R5

    AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
        ctl_write |=> remap_sram == $past(bus_wdata[0])); // R6

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl_write |=> $stable(remap_sram)); // R12

    AST_CTL_READ: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[DATA_W-1:1] == '0 && ctl_rdata[0] == remap_sram); // R7

    AST_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !in_map |-> bus_abort && !sel_sram && !sel_flash && !sel_regs); // R8

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_sram, sel_flash, sel_regs, bus_abort})); // R8

    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_abort |-> $countones(bus_be) == (1 << bus_size)); // R9

    AST_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_size == 2'd2 && bus_addr[1:0] != 2'd0
        |-> bus_abort && bus_be == '0); // R10

    AST_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> !bus_abort && bus_be == '0 && !sel_sram && !sel_flash && !sel_regs); // R11
endmodule

bind memmap_decoder memmap_decoder_chk chk_i (.*);

// File: tb/memmap_decoder_tb_top.sv
module memmap_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid;
    logic        bus_write;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic        sel_sram, sel_flash, sel_regs, bus_abort, remap_sram;
    logic [14:0] local_off;
    logic [3:0]  bus_be;
    logic [31:0] ctl_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memmap_decoder dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .sel_sram(sel_sram), .sel_flash(sel_flash), .sel_regs(sel_regs),
        .bus_abort(bus_abort), .local_off(local_off), .bus_be(bus_be),
        .ctl_rdata(ctl_rdata), .remap_sram(remap_sram)
    );

    // sel code: {regs, flash, sram}
    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic [2:0]  sel;
        logic        abort;
        logic [14:0] off;
        logic [3:0]  be;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 2'd2, 3'b010, 1'b0, 15'h0000, 4'hF}, // R5
        '{32'h0000_7FFC, 2'd2, 3'b010, 1'b0, 15'h7FFC, 4'hF}, // R5
        '{32'h0000_8000, 2'd2, 3'b000, 1'b1, 15'h0000, 4'h0}, // R8
        '{32'h0004_0000, 2'd0, 3'b001, 1'b0, 15'h0000, 4'h1}, // R2
        '{32'h0004_0FFF, 2'd0, 3'b001, 1'b0, 15'h0FFF, 4'h8}, // R2
        '{32'h0004_1000, 2'd0, 3'b000, 1'b1, 15'h0000, 4'h0}, // R8
        '{32'h0003_FFFC, 2'd2, 3'b000, 1'b1, 15'h0000, 4'h0}, // R8
        '{32'h0008_0002, 2'd1, 3'b010, 1'b0, 15'h0002, 4'hC}, // R3
        '{32'h0008_7FFE, 2'd1, 3'b010, 1'b0, 15'h7FFE, 4'hC}, // R3
        '{32'h0008_8000, 2'd2, 3'b000, 1'b1, 15'h0000, 4'h0}, // R8
        '{32'hFFFF_0FFC, 2'd2, 3'b100, 1'b0, 15'h0FFC, 4'hF}, // R4
        '{32'hFFFF_1000, 2'd2, 3'b000, 1'b1, 15'h0000, 4'h0}, // R8
        '{32'hFFFE_FFFC, 2'd2, 3'b000, 1'b1, 15'h0000, 4'h0}, // R8
        '{32'h0004_0001, 2'd1, 3'b000, 1'b1, 15'h0000, 4'h0}, // R10
        '{32'h0004_0002, 2'd2, 3'b000, 1'b1, 15'h0000, 4'h0}, // R10
        '{32'h0004_0004, 2'd3, 3'b000, 1'b1, 15'h0000, 4'h0}, // R9
        '{32'h0004_0101, 2'd0, 3'b001, 1'b0, 15'h0101, 4'h2}  // R9
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at falling edge, settle one step
    task automatic drive(input logic v, input logic w, input logic [31:0] a,
                         input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_size = s; bus_wdata = d;
        #1;
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic expect_route(input string req, input logic [2:0] sel, input logic ab,
                                input logic [14:0] off, input logic [3:0] be);
        check(req, {60'd0, sel_regs, sel_flash, sel_sram, bus_abort}, {60'd0, sel, ab});
        check(req, {49'd0, local_off}, {49'd0, off});
        check(req, {60'd0, bus_be}, {60'd0, be});
    endtask

    initial begin
        rst = 1'b1; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_size = 0; bus_wdata = 0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset remap", {63'd0, remap_sram}, 64'd0);
        check("R1 reset rdata", {32'd0, ctl_rdata}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, 1'b0, VECS[i].addr, VECS[i].size, 32'd0);
            expect_route($sformatf("R2-table row %0d", i), VECS[i].sel, VECS[i].abort,
                         VECS[i].off, VECS[i].be);
        end

        // R11: idle bus, ctl write with valid low
        drive(1'b0, 1'b1, 32'hFFFF_0000, 2'd2, 32'd1);
        expect_route("R11 idle", 3'b000, 1'b0, 15'd0, 4'd0);
        edge_step();
        check("R11 no load", {63'd0, remap_sram}, 64'd0);

        // R12: other page offset
        drive(1'b1, 1'b1, 32'hFFFF_0004, 2'd2, 32'd1);
        expect_route("R12 other reg", 3'b100, 1'b0, 15'h0004, 4'hF);
        edge_step();
        check("R12 other offset", {63'd0, remap_sram}, 64'd0);

        // R6: set remap
        drive(1'b1, 1'b1, 32'hFFFF_0000, 2'd2, 32'd1);
        edge_step();
        check("R6 set", {63'd0, remap_sram}, 64'd1);
        check("R7 read one", {32'd0, ctl_rdata}, 64'd1);
        drive(1'b1, 1'b0, 32'h0000_0010, 2'd2, 32'd0);
        expect_route("R6 low sram", 3'b001, 1'b0, 15'h0010, 4'hF);
        drive(1'b1, 1'b0, 32'h0000_1010, 2'd2, 32'd0);
        expect_route("R6 wrap", 3'b001, 1'b0, 15'h0010, 4'hF);
        drive(1'b1, 1'b0, 32'h0000_7FFE, 2'd1, 32'd0);
        expect_route("R6 wrap top", 3'b001, 1'b0, 15'h0FFE, 4'hC);

        // R12: read of ctl keeps bit
        drive(1'b1, 1'b0, 32'hFFFF_0000, 2'd2, 32'd0);
        edge_step();
        check("R12 read keeps", {63'd0, remap_sram}, 64'd1);

        // R6: byte write clears
        drive(1'b1, 1'b1, 32'hFFFF_0000, 2'd0, 32'hFFFF_FFFE);
        edge_step();
        check("R6 clear", {63'd0, remap_sram}, 64'd0);
        drive(1'b1, 1'b0, 32'h0000_1010, 2'd2, 32'd0);
        expect_route("R5 flash back", 3'b010, 1'b0, 15'h1010, 4'hF);

        // R7: upper bits read zero
        drive(1'b1, 1'b1, 32'hFFFF_0000, 2'd2, 32'hFFFF_FFFF);
        edge_step();
        check("R7 upper zero", {32'd0, ctl_rdata}, 64'd1);

        // R1: reset with remap set
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset clears", {63'd0, remap_sram}, 64'd0);
        rst = 1'b0;
        drive(1'b1, 1'b0, 32'h0000_0004, 2'd2, 32'd0);
        expect_route("R1 flash low", 3'b010, 1'b0, 15'h0004, 4'hF);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule